// File: doc/BRIEF.md
# Two-Wire Memory Slave Address Front End

This block sits between the two-wire serial bus pins and the controller of a serial memory device. It samples the clock and data lines with the system clock, recognises the bus conditions that open and close a transfer, shifts in the slave address byte, and decides whether this device is being addressed. When it is addressed, it pulls the data line low for the acknowledge clock and hands the downstream controller a one-cycle strobe. The strobe carries the requested direction and says whether the byte selected the memory array or the permanent write-protect command.

Outside a transfer the block watches the bus but does not respond. A new opening condition always restarts address reception, even in the middle of a byte. A standby flag reports when the device may rest: after reset, after a closing condition that did not end a write command, and once the downstream controller reports that an internal write has finished. The data line is open-drain, so the block only outputs a pull-low enable.

Top module: `twi_addr_frontend`

## Requirements
- R1: An opening condition is the data line falling while the clock line is high, and a closing condition is the data line rising while the clock line is high. A closing condition ends any transfer and clears `busy_o`.
- R2: Address bits are taken on each rising clock-line edge, most significant bit first. Byte 0x55 must not be acknowledged when the straps are 3'b101, because its bit-reversed form would match.
- R3: Bus clocks and data that arrive before any opening condition produce no acknowledge and no strobe.
- R4: Address bits [7:4] equal to 4'b1010 select memory access (`is_wp_cmd_o`=0), and 4'b0110 selects the write-protect command (`is_wp_cmd_o`=1). Any other value gets no acknowledge.
- R5: Address bits [3:1] must equal `strap_i[2:0]`. On a mismatch there is no acknowledge, and the block stays idle until the next opening condition.
- R6: Address bit 0 gives the direction, and `rw_read_o` takes its value: 1 is read, 0 is write.
- R7: When addressed, `sda_pull_o` goes high during the low phase after the eighth address bit and stays high through the ninth clock's high phase. It drops after the ninth clock falls.
- R8: An opening condition at any point, including mid-byte and during `busy_o`, restarts address reception at bit 7.
- R9: `standby_o` is 1 after reset and after a closing condition with no write pending. A write command that is acknowledged and then closed leaves it 0 until `write_done_i` pulses.
- R10: After the acknowledge clock, `addr_valid_o` pulses for one cycle with `is_wp_cmd_o` and `rw_read_o` valid, and `busy_o` rises. `busy_o` holds until the next opening or closing condition, and the block pulls nothing while busy.
- R11: `standby_o` falls after an opening condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Chip-select straps {A2,A1,A0} |
| write_done_i | input | 1 | Pulse from controller: internal write finished |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| addr_valid_o | output | 1 | One-cycle strobe after an acknowledged address |
| is_wp_cmd_o | output | 1 | Selected the write-protect command |
| rw_read_o | output | 1 | 1 = read requested, 0 = write |
| busy_o | output | 1 | Addressed transfer in progress |
| standby_o | output | 1 | Device may enter low-power standby |

## Verification
The hardest situation to reach is an opening condition that arrives in the middle of an address byte. It needs a bus model that stops clocking after a few bits and raises the data line while the clock is still low, so that it can then form a clean opening condition. The bench drives a wired-AND bus from a model of the master. Each acknowledged address pushes an expected record to a scoreboard, which a monitor pops on every strobe. The bench aborts partial bytes and restarts from the busy state, and it sends a byte whose bit-reversed form would match, to show that the bits are taken in the right order.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_BYTE_END,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_BUSY
  } fe_state_t;

  localparam logic [3:0] PRE_MEM = 4'b1010;
  localparam logic [3:0] PRE_WP  = 4'b0110;
endpackage

// File: rtl/twi_sync_cond.sv
module twi_sync_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_q, sda_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[0] <= 1'b1;
            sda_pipe[0] <= 1'b1;
          end else begin
            scl_pipe[0] <= scl_i;
            sda_pipe[0] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[g] <= 1'b1;
            sda_pipe[g] <= 1'b1;
          end else begin
            scl_pipe[g] <= scl_pipe[g-1];
            sda_pipe[g] <= sda_pipe[g-1];
          end
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
endmodule

// File: rtl/twi_addr_fsm.sv
module twi_addr_fsm
  import twi_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               write_done_i,
  output logic               sda_pull_o,
  output logic               addr_valid_o,
  output logic               is_wp_cmd_o,
  output logic               rw_read_o,
  output logic               busy_o,
  output logic               standby_o
);
  localparam int CNT_W = $clog2(ADDR_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_W - 1);

  fe_state_t          state, state_n;
  logic [ADDR_W-1:0]  shreg, shreg_n;
  logic [CNT_W-1:0]   cnt, cnt_n;
  logic               valid_n, wp_n, rd_n, stby_n, wrp, wrp_n;
  logic               pre_ok, strap_ok, match;

  assign pre_ok   = (shreg[ADDR_W-1 -: 4] == PRE_MEM) || (shreg[ADDR_W-1 -: 4] == PRE_WP);
  assign strap_ok = (shreg[STRAP_W:1] == strap_i);
  assign match    = pre_ok & strap_ok;

  always_comb begin
    state_n = state;
    shreg_n = shreg;
    cnt_n   = cnt;
    valid_n = 1'b0;
    wp_n    = is_wp_cmd_o;
    rd_n    = rw_read_o;
    stby_n  = standby_o;
    wrp_n   = wrp;
    if (start_det) begin
      state_n = ST_RECV;
      cnt_n   = '0;
      stby_n  = 1'b0;
    end else if (stop_det) begin
      state_n = ST_IDLE;
      if (!wrp) stby_n = 1'b1;
    end else begin
      unique case (state)
        ST_RECV: if (scl_rise) begin
          shreg_n = {shreg[ADDR_W-2:0], sda_s};
          cnt_n   = cnt + 1'b1;
          if (cnt == LAST_BIT) state_n = ST_BYTE_END;
        end
        ST_BYTE_END: if (scl_fall) state_n = match ? ST_ACK_LO : ST_IDLE;
        ST_ACK_LO:   if (scl_rise) state_n = ST_ACK_HI;
        ST_ACK_HI: if (scl_fall) begin
          state_n = ST_BUSY;
          valid_n = 1'b1;
          wp_n    = (shreg[ADDR_W-1 -: 4] == PRE_WP);
          rd_n    = shreg[0];
          if (!shreg[0]) wrp_n = 1'b1;
        end
        default: ;
      endcase
    end
    if (write_done_i) begin
      wrp_n = 1'b0;
      if (!start_det) stby_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      shreg        <= '0;
      cnt          <= '0;
      addr_valid_o <= 1'b0;
      is_wp_cmd_o  <= 1'b0;
      rw_read_o    <= 1'b0;
      standby_o    <= 1'b1;
      wrp          <= 1'b0;
    end else begin
      state        <= state_n;
      shreg        <= shreg_n;
      cnt          <= cnt_n;
      addr_valid_o <= valid_n;
      is_wp_cmd_o  <= wp_n;
      rw_read_o    <= rd_n;
      standby_o    <= stby_n;
      wrp          <= wrp_n;
    end
  end

  assign sda_pull_o = (state == ST_ACK_LO) || (state == ST_ACK_HI);
  assign busy_o     = (state == ST_BUSY);
endmodule

// File: rtl/twi_addr_frontend.sv
module twi_addr_frontend #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8,
  parameter int STRAP_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               write_done_i,
  output logic               sda_pull_o,
  output logic               addr_valid_o,
  output logic               is_wp_cmd_o,
  output logic               rw_read_o,
  output logic               busy_o,
  output logic               standby_o
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       scl_s, sda_s, start_det, stop_det, scl_rise, scl_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  twi_sync_cond #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  twi_addr_fsm #(.ADDR_W(ADDR_W), .STRAP_W(STRAP_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .sda_s        (sda_s),
    .strap_i      (strap_i),
    .write_done_i (write_done_i),
    .sda_pull_o   (sda_pull_o),
    .addr_valid_o (addr_valid_o),
    .is_wp_cmd_o  (is_wp_cmd_o),
    .rw_read_o    (rw_read_o),
    .busy_o       (busy_o),
    .standby_o    (standby_o)
  );
endmodule

// File: rtl/twi_addr_frontend_chk.sv
module twi_addr_frontend_chk (
  input logic clk,
  input logic rst_n,
  input logic start_det,
  input logic stop_det,
  input logic scl_s,
  input logic sda_pull_o,
  input logic addr_valid_o,
  input logic busy_o,
  input logic standby_o
);
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!busy_o && !sda_pull_o)); // R1
  AST_PULL_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s); // R7
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!busy_o && !sda_pull_o)); // R8
  AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o |=> !addr_valid_o); // R10
  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o |-> busy_o); // R10
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_pull_o); // R10
  AST_START_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !standby_o); // R11
endmodule

bind twi_addr_frontend twi_addr_frontend_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_det    (start_det),
  .stop_det     (stop_det),
  .scl_s        (scl_s),
  .sda_pull_o   (sda_pull_o),
  .addr_valid_o (addr_valid_o),
  .busy_o       (busy_o),
  .standby_o    (standby_o)
);

// File: tb/sim_twi_addr_frontend.sv
`timescale 1ns/1ps
module sim_twi_addr_frontend;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic wdone = 1'b0;
  logic sda_pull, addr_valid, is_wp, rd, busy, stby;
  wire  sda_line = sda_m & ~sda_pull;

  int n_chk = 0, n_fail = 0;

  typedef struct packed { logic wp; logic rd; } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  twi_addr_frontend u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .write_done_i(wdone), .sda_pull_o(sda_pull),
    .addr_valid_o(addr_valid), .is_wp_cmd_o(is_wp), .rw_read_o(rd),
    .busy_o(busy), .standby_o(stby)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ackbit, output logic pull_lo);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq();
    pull_lo = sda_pull;
    scl_m = 1'b1; wq();
    ackbit = sda_line;
    wq(); scl_m = 1'b0; wq();
  endtask

  // scoreboard driver: push expectation, send address, check acknowledge
  task automatic addr(input logic [7:0] b, input logic exp_ack, input string req);
    logic ab, pl;
    exp_t e;
    e.wp = (b[7:4] == 4'b0110);
    e.rd = b[0];
    if (exp_ack) sb_q.push_back(e);
    send_byte(b, ab, pl);
    chk(ab == !exp_ack, req, int'(ab), int'(!exp_ack));
    if (exp_ack) chk(pl == 1'b1, "R7 pull in low phase", int'(pl), 1);
    chk(sda_pull == 1'b0, "R7 release after ninth clock", int'(sda_pull), 0);
  endtask

  // monitor: pop expectations on each strobe
  always @(negedge clk) begin
    if (rst_n && addr_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10 unexpected strobe", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(is_wp == e.wp, "R4 wp field", int'(is_wp), int'(e.wp));
        chk(rd == e.rd, "R6 rw field", int'(rd), int'(e.rd));
        chk(busy == 1'b1, "R10 busy with strobe", int'(busy), 1);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic ab, pl;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(stby == 1'b1, "R9 standby after reset", int'(stby), 1);
    chk(sda_pull == 1'b0 && busy == 1'b0 && addr_valid == 1'b0, "R9 reset outputs quiet",
        int'({sda_pull, busy, addr_valid}), 0);

    // R3: traffic before any opening condition
    scl_m = 1'b0; wq();
    addr(8'b1010_101_0, 1'b0, "R3 no ack before start");
    chk(busy == 1'b0, "R3 not busy", int'(busy), 0);

    // memory write, then data in busy ignored
    bus_start();
    chk(stby == 1'b0, "R11 standby falls on start", int'(stby), 0);
    addr(8'b1010_101_0, 1'b1, "R4 R5 memory write ack");
    chk(busy == 1'b1, "R10 busy after ack", int'(busy), 1);
    send_byte(8'h00, ab, pl);
    chk(ab == 1'b1, "R10 no pull while busy", int'(ab), 1);
    chk(busy == 1'b1, "R10 busy held", int'(busy), 1);
    bus_stop();
    chk(busy == 1'b0, "R1 stop clears busy", int'(busy), 0);
    chk(stby == 1'b0, "R9 write pending holds standby low", int'(stby), 0);
    wdone = 1'b1; @(negedge clk); wdone = 1'b0; repeat (2) @(negedge clk);
    chk(stby == 1'b1, "R9 write_done sets standby", int'(stby), 1);

    // memory read
    bus_start();
    addr(8'b1010_101_1, 1'b1, "R6 read ack");
    bus_stop();
    chk(stby == 1'b1, "R9 standby after read stop", int'(stby), 1);

    // write-protect command
    bus_start();
    addr(8'b0110_101_0, 1'b1, "R4 write-protect ack");
    bus_stop();
    wdone = 1'b1; @(negedge clk); wdone = 1'b0; repeat (2) @(negedge clk);

    // bad preamble, strap mismatch, bit order
    bus_start();
    addr(8'b1011_101_0, 1'b0, "R4 bad preamble nack");
    bus_start();
    addr(8'b1010_100_1, 1'b0, "R5 strap mismatch nack");
    send_byte(8'b1010_101_1, ab, pl);
    chk(ab == 1'b1, "R5 idle until next start", int'(ab), 1);
    bus_start();
    addr(8'b0101_0101, 1'b0, "R2 msb first");
    bus_stop();

    // R8: abort mid-byte
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    addr(8'b0110_101_1, 1'b1, "R8 restart mid-byte");
    // R8: restart from busy
    bus_start();
    chk(busy == 1'b0, "R8 start leaves busy", int'(busy), 0);
    addr(8'b1010_101_1, 1'b1, "R8 restart from busy");
    bus_stop();

    // other strap value
    strap = 3'b010;
    bus_start();
    addr(8'b1010_010_0, 1'b1, "R5 second strap value");
    bus_stop();
    wdone = 1'b1; @(negedge clk); wdone = 1'b0; repeat (4) @(negedge clk);

    chk(sb_q.size() == 0, "R10 all strobes seen", sb_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule